// File: doc/BRIEF.md
# Serial-Programmed Control Latch Bank

This block receives configuration words over a three-wire serial link (serial clock, serial data, load strobe) and holds them in four internal latches. A 24-bit shift register accepts one data bit per rising edge of the serial clock, most significant bit first. A rising edge on the load strobe copies the shifted word into one latch. The two lowest bits of the word select that latch.

The four latches are the reference latch, the feedback-count latch, the function latch and the initialization latch. Each latch keeps the 22 bits above the select field. The fields the rest of the device needs come straight out of these words: a reference divide count, A and B feedback counts, an antibacklash width select, a lock-detect precision bit and an output-mux select.

All three serial inputs pass through a synchronizer into the system clock domain. Edges of the serial clock and of the load strobe are detected there, so the whole block runs on one clock.

Top module: `serial_latch_bank`

## Requirements
- R1: While rst_ni is low, and after reset is released, all four latch words and every decoded field read zero.
- R2: Select code 00 in word bits [1:0] writes word bits [23:2] into the reference latch. The reference count is word bits [15:2], the antibacklash select is bits [17:16] and the precision bit is bit 18.
- R3: Select code 01 writes the feedback-count latch. The A count is word bits [7:2] and the B count is word bits [20:8].
- R4: Select code 10 writes the function latch. The output-mux select is word bits [4:2].
- R5: Select code 11 writes word bits [23:2] into both the initialization latch and the function latch.
- R6: A load changes only the latch (or, for code 11, the pair of latches) that its select code names. The others keep their values.
- R7: A transfer happens only on a rising edge of the load strobe. Keeping the strobe high while further bits are shifted in leaves every latch unchanged until the next rising edge.
- R8: When more than 24 bits arrive before a load, only the last 24 bits shifted in are transferred.
- R9: Shifting bits in with no load edge leaves every latch unchanged.
- R10: The serial bit order is MSB first: the first of 24 bits shifted in ends up in word bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first |
| sload_i | input | 1 | Load strobe; its rising edge transfers the word |
| ref_cnt_o | output | 14 | Reference divide count |
| abw_sel_o | output | 2 | Antibacklash width select |
| ldp_o | output | 1 | Lock-detect precision bit |
| a_cnt_o | output | 6 | A feedback count |
| b_cnt_o | output | 13 | B feedback count |
| mux_sel_o | output | 3 | Output-mux select |
| ref_word_o | output | 22 | Reference latch contents |
| ab_word_o | output | 22 | Feedback-count latch contents |
| func_word_o | output | 22 | Function latch contents |
| init_word_o | output | 22 | Initialization latch contents |

## Verification
The bench uses the default parameters: a 24-bit word, field widths 14/6/13 and a two-stage synchronizer. With these values all four select codes can be swept, each with several arithmetically generated payloads. After every load the bench compares all four latch words with a model of its own. These sweeps reach the code-11 double write and show that untargeted latches keep their values. Further sequences cover a strobe held high while bits are shifted, a word of more than 24 bits, and shifting with no load.

// File: rtl/slb_pkg.sv
package slb_pkg;
  typedef enum logic [1:0] {
    SEL_REF  = 2'b00,
    SEL_AB   = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_INIT = 2'b11
  } latch_sel_e;

  localparam int unsigned NUM_LATCH = 4;
  localparam int unsigned SEL_W     = 2;
endpackage

// File: rtl/slb_sync.sv
module slb_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/slb_shift.sv
module slb_shift #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  // MSB first: older bits move toward the top, extra leading bits fall off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_q <= '0;
    else if (shift_en_i) word_q <= {word_q[WORD_W-2:0], bit_i};
  end

  assign word_o = word_q;
endmodule

// File: rtl/slb_latches.sv
module slb_latches
  import slb_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned PAY_W = WORD_W - SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [PAY_W-1:0]  ref_o,
  output logic [PAY_W-1:0]  ab_o,
  output logic [PAY_W-1:0]  func_o,
  output logic [PAY_W-1:0]  init_o
);
  latch_sel_e         sel;
  logic [PAY_W-1:0]   payload;
  logic [PAY_W-1:0]   latch_q [NUM_LATCH];

  assign sel     = latch_sel_e'(word_i[SEL_W-1:0]);
  assign payload = word_i[WORD_W-1:SEL_W];

  for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
    logic we;
    // init load also refreshes the function latch
    assign we = load_i && ((sel == latch_sel_e'(g)) ||
                           (g == int'(SEL_FUNC) && sel == SEL_INIT));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  latch_q[g] <= '0;
      else if (we)  latch_q[g] <= payload;
    end
  end

  assign ref_o  = latch_q[SEL_REF];
  assign ab_o   = latch_q[SEL_AB];
  assign func_o = latch_q[SEL_FUNC];
  assign init_o = latch_q[SEL_INIT];
endmodule

// File: rtl/serial_latch_bank.sv
module serial_latch_bank
  import slb_pkg::*;
#(
  parameter int unsigned WORD_W      = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REF_W       = 14,
  parameter int unsigned A_W         = 6,
  parameter int unsigned B_W         = 13,
  parameter int unsigned ABW_W       = 2,
  parameter int unsigned MUX_W       = 3,
  localparam int unsigned PAY_W      = WORD_W - SEL_W,
  localparam int unsigned ABW_LSB    = REF_W,
  localparam int unsigned LDP_BIT    = ABW_LSB + ABW_W,
  localparam int unsigned B_LSB      = A_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             sload_i,
  output logic [REF_W-1:0] ref_cnt_o,
  output logic [ABW_W-1:0] abw_sel_o,
  output logic             ldp_o,
  output logic [A_W-1:0]   a_cnt_o,
  output logic [B_W-1:0]   b_cnt_o,
  output logic [MUX_W-1:0] mux_sel_o,
  output logic [PAY_W-1:0] ref_word_o,
  output logic [PAY_W-1:0] ab_word_o,
  output logic [PAY_W-1:0] func_word_o,
  output logic [PAY_W-1:0] init_word_o
);
  logic [2:0]        sync_lvl;
  logic [1:0]        prev_q;
  logic              sclk_rise;
  logic              load_pulse;
  logic [WORD_W-1:0] shift_word;

  // bit 2 load, bit 1 serial clock, bit 0 data: equal latency keeps them aligned
  slb_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sload_i, sclk_i, sdata_i}),
    .sync_o  (sync_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_lvl[2:1];
  end

  assign sclk_rise  = sync_lvl[1] & ~prev_q[0];
  assign load_pulse = sync_lvl[2] & ~prev_q[1];

  slb_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (sclk_rise),
    .bit_i      (sync_lvl[0]),
    .word_o     (shift_word)
  );

  slb_latches #(.WORD_W(WORD_W)) u_latches (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_pulse),
    .word_i (shift_word),
    .ref_o  (ref_word_o),
    .ab_o   (ab_word_o),
    .func_o (func_word_o),
    .init_o (init_word_o)
  );

  assign ref_cnt_o = ref_word_o[REF_W-1:0];
  assign abw_sel_o = ref_word_o[ABW_LSB +: ABW_W];
  assign ldp_o     = ref_word_o[LDP_BIT];
  assign a_cnt_o   = ab_word_o[A_W-1:0];
  assign b_cnt_o   = ab_word_o[B_LSB +: B_W];
  assign mux_sel_o = func_word_o[MUX_W-1:0];
endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned PAY_W = WORD_W - 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_pulse_i,
  input logic [WORD_W-1:0] shift_word_i,
  input logic [PAY_W-1:0]  ref_word_i,
  input logic [PAY_W-1:0]  ab_word_i,
  input logic [PAY_W-1:0]  func_word_i,
  input logic [PAY_W-1:0]  init_word_i
);
  a_r2_ref_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pulse_i && shift_word_i[1:0] == 2'b00 |=> ref_word_i == $past(shift_word_i[WORD_W-1:2]));

  a_r3_ab_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pulse_i && shift_word_i[1:0] == 2'b01 |=> ab_word_i == $past(shift_word_i[WORD_W-1:2]));

  a_r5_init_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pulse_i && shift_word_i[1:0] == 2'b11 |=> func_word_i == init_word_i);

  a_r6_ref_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pulse_i && shift_word_i[1:0] != 2'b00 |=> $stable(ref_word_i));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pulse_i |=> !load_pulse_i);

  a_r9_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_pulse_i |=> $stable(ref_word_i) && $stable(ab_word_i) &&
                      $stable(func_word_i) && $stable(init_word_i));
endmodule

bind serial_latch_bank slb_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .load_pulse_i (load_pulse),
  .shift_word_i (shift_word),
  .ref_word_i   (ref_word_o),
  .ab_word_i    (ab_word_o),
  .func_word_i  (func_word_o),
  .init_word_i  (init_word_o)
);

// File: tb/sim_serial_latch_bank.sv
module sim_serial_latch_bank;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [13:0] ref_cnt;
  logic [1:0]  abw_sel;
  logic        ldp;
  logic [5:0]  a_cnt;
  logic [12:0] b_cnt;
  logic [2:0]  mux_sel;
  logic [21:0] ref_w, ab_w, fn_w, in_w;
  logic [21:0] e_ref = '0, e_ab = '0, e_fn = '0, e_in = '0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_latch_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata), .sload_i(sload),
    .ref_cnt_o(ref_cnt), .abw_sel_o(abw_sel), .ldp_o(ldp), .a_cnt_o(a_cnt),
    .b_cnt_o(b_cnt), .mux_sel_o(mux_sel), .ref_word_o(ref_w), .ab_word_o(ab_w),
    .func_word_o(fn_w), .init_word_o(in_w)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) sdata = w[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_load();
    @(negedge clk) sload = 1'b1;
    repeat (6) @(negedge clk);
    sload = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // bench model: code 00 ref, 01 ab, 10 func, 11 init+func
  task automatic model(input logic [23:0] w);
    case (w[1:0])
      2'b00: e_ref = w[23:2];
      2'b01: e_ab  = w[23:2];
      2'b10: e_fn  = w[23:2];
      default: begin e_in = w[23:2]; e_fn = w[23:2]; end
    endcase
  endtask

  task automatic check_all(input string req);
    check({req, " ref"},  32'(ref_w), 32'(e_ref));
    check({req, " ab"},   32'(ab_w),  32'(e_ab));
    check({req, " func"}, 32'(fn_w),  32'(e_fn));
    check({req, " init"}, 32'(in_w),  32'(e_in));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after reset");
    check("R1 fields", {ref_cnt, abw_sel, ldp, a_cnt, b_cnt, mux_sel}, 32'h0);

    // sweep: every code, several payloads (R2 R3 R4 R5 R6 R10)
    for (int code = 0; code < 4; code++) begin
      for (int k = 0; k < 5; k++) begin
        logic [21:0] p;
        logic [23:0] w;
        p = 22'(k * 32'h1357B + code * 32'h2A5D + 32'h15);
        if (k == 3) p = '1;
        if (k == 4) p = 22'h200001;
        w = {p, 2'(code)};
        shift_bits(32'(w), 24);
        pulse_load();
        model(w);
        check_all($sformatf("R6 sweep code=%0d k=%0d", code, k));
        case (code)
          0: begin
            check("R2 ref_cnt", 32'(ref_cnt), 32'(w[15:2]));
            check("R2 abw_sel", 32'(abw_sel), 32'(w[17:16]));
            check("R2 ldp", 32'(ldp), 32'(w[18]));
          end
          1: begin
            check("R3 a_cnt", 32'(a_cnt), 32'(w[7:2]));
            check("R3 b_cnt", 32'(b_cnt), 32'(w[20:8]));
          end
          2: check("R4 mux_sel", 32'(mux_sel), 32'(w[4:2]));
          default: check("R5 func mirrors init", 32'(fn_w), 32'(in_w));
        endcase
      end
    end

    // R10: single marker bit shifted first lands in bit 23
    shift_bits(32'h800000, 24);
    pulse_load();
    model(24'h800000);
    check("R10 msb first", 32'(ref_w), 32'h200000);

    // R9: shifting without load
    shift_bits(32'h3C3C3D, 24);
    check_all("R9 no load");

    // R7: strobe held high while a new word arrives
    shift_bits(32'h0F0F02, 24);
    @(negedge clk) sload = 1'b1;
    repeat (8) @(negedge clk);
    model(24'h0F0F02);
    check_all("R7 first edge");
    shift_bits(32'h5A5A01, 24);
    check_all("R7 held high");
    sload = 1'b0;
    repeat (6) @(negedge clk);
    check_all("R7 after fall");
    pulse_load();
    model(24'h5A5A01);
    check_all("R7 next edge");

    // R8: 30 bits, only the last 24 kept
    shift_bits(32'h3F_ABCDE1 & 32'h3FFFFFFF, 30);
    pulse_load();
    model(24'hABCDE1);
    check_all("R8 overlong");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule